// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt status flags of a 16-bit timer/counter that has up to four compare/capture channels. The counter, compare logic, fault logic and quadrature decoder sit outside it. Each of them reports to this block through a single-cycle event strobe. The block turns those strobes into sticky flags. It presents the flags as one 8-bit status byte and derives from them the interrupt requests and the DMA requests.

How a flag is cleared depends on the operating mode. In the waveform modes, a channel flag is released when its interrupt vector is acknowledged. In capture mode, it is released when software reads the channel's capture register, and the acknowledge has no effect. In every mode, software can clear any flag by writing a one to its bit. A DMA access to a channel's compare/capture register or buffer register drops that channel's flag, and with it the DMA request. A DMA write to the count, period or period-buffer register does the same for the overflow flag. When a set and a clear reach the same flag in one cycle, the set wins.

All flags are registered. A stimulus applied before a rising edge is visible on `flags_o` right after that edge. The request outputs are combinational functions of the flags and the enables.

Top module: `tc_irq_flags`

## Requirements
- R1: After reset, all eight bits of `flags_o` are 0 and every interrupt and DMA request output is low.
- R2: Bits 3:2 of `flags_o` always read 0. A register write that sets those bits in `reg_wdata_i` changes no flag.
- R3: In any mode other than capture (mode code 4), a `cmp_match_i[k]` pulse sets the flag of channel k, which is `flags_o[4+k]`. A `cap_valid_i` pulse has no effect in these modes.
- R4: In any mode other than capture, `ack_ch_i[k]` clears the channel k flag. A `cc_rd_i[k]` pulse does not clear it.
- R5: In capture mode (code 4), `cap_valid_i[k]` sets the channel k flag and `cc_rd_i[k]` clears it. In this mode `ack_ch_i[k]` does not clear it, and `cmp_match_i` has no effect.
- R6: A register write (`reg_wr_i` high) clears every flag whose bit in `reg_wdata_i` is 1 and leaves flags whose bit is 0 unchanged.
- R7: `dma_ch_req_o[k]` equals the channel k flag. A `dma_cc_i[k]` pulse clears that flag in every mode.
- R8: The error flag `flags_o[1]` is set in three cases: by `fault_i` in frequency (1), single-slope PWM (2) or dual-slope PWM (3) mode when `HAS_FAULT_EXT` is 1; by any `cap_ovf_i` bit in capture mode (4); and by `qdec_idx_err_i` in quadrature mode (5). Each of these inputs is ignored in the other modes.
- R9: The overflow flag `flags_o[0]` is set by `cnt_bottom_i` in dual-slope PWM mode (3), and by `cnt_top_i` in every other mode.
- R10: The overflow flag is cleared by `ack_ovf_i`, by a write of one to bit 0, or by `dma_cnt_wr_i`. `dma_ovf_req_o` equals the overflow flag.
- R11: When a set event and a clear event reach the same flag in one cycle, the flag ends up set.
- R12: `irq_ch_o[k]`, `irq_err_o` and `irq_ovf_o` are each high only while their flag and their enable input are both high.
- R13: The error flag is cleared by `ack_err_i` or by a write of one to bit 1. DMA strobes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Mode: 0 normal, 1 frequency, 2 single-slope PWM, 3 dual-slope PWM, 4 capture, 5 quadrature |
| cmp_match_i | input | NCH | Compare match strobe per channel |
| cap_valid_i | input | NCH | Capture buffer became valid, per channel |
| cap_ovf_i | input | NCH | Capture buffer overflow, per channel |
| fault_i | input | 1 | Fault detect strobe |
| qdec_idx_err_i | input | 1 | Bad quadrature index strobe |
| cnt_top_i | input | 1 | Counter reached TOP |
| cnt_bottom_i | input | 1 | Counter reached BOTTOM |
| ack_ch_i | input | NCH | Channel vector acknowledge |
| ack_err_i | input | 1 | Error vector acknowledge |
| ack_ovf_i | input | 1 | Overflow vector acknowledge |
| reg_wr_i | input | 1 | CPU write to the flag register |
| reg_wdata_i | input | 8 | Write data, a one clears that flag |
| cc_rd_i | input | NCH | CPU read of channel capture register |
| dma_cc_i | input | NCH | DMA access to channel compare/capture or buffer register |
| dma_cnt_wr_i | input | 1 | DMA write to count, period or period-buffer register |
| en_ch_i | input | NCH | Channel interrupt enables |
| en_err_i | input | 1 | Error interrupt enable |
| en_ovf_i | input | 1 | Overflow interrupt enable |
| flags_o | output | 8 | Flag byte: 7..4 channels D..A, 3:2 zero, 1 error, 0 overflow |
| irq_ch_o | output | NCH | Channel interrupt requests |
| irq_err_o | output | 1 | Error interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| dma_ch_req_o | output | NCH | Channel DMA requests |
| dma_ovf_req_o | output | 1 | Overflow DMA request |

## Verification
Each stimulus lasts one cycle. Its effect on `flags_o` is due exactly one rising edge later, because a single register lies between every strobe and its flag. The request outputs follow the flags within that same cycle. The driver applies a stimulus on a falling edge and queues the flag byte expected after the next rising edge. The monitor pops that entry shortly after the edge and compares the flags, the interrupt requests (computed from the queued enables) and the DMA requests. Because each entry is checked in the single cycle its result is due, an early or late flag update shows up as a mismatch.

// File: rtl/tc_irq_pkg.sv
package tc_irq_pkg;

   typedef enum logic [2:0] {
      TM_NORMAL  = 3'd0,
      TM_FREQ    = 3'd1,
      TM_PWM_SS  = 3'd2,
      TM_PWM_DS  = 3'd3,
      TM_CAPTURE = 3'd4,
      TM_QDEC    = 3'd5
   } tc_mode_e;

   localparam int FLAG_W  = 8;
   localparam int OVF_BIT = 0;
   localparam int ERR_BIT = 1;
   localparam int CH_BASE = 4;
   localparam int MAX_CH  = 4;

   function automatic logic is_fault_mode(input tc_mode_e m);
      return (m == TM_FREQ) || (m == TM_PWM_SS) || (m == TM_PWM_DS);
   endfunction

endpackage

// File: rtl/tc_irq_chan_flag.sv
module tc_irq_chan_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_mode_i,
   input  logic cmp_match_i,
   input  logic cap_valid_i,
   input  logic ack_i,
   input  logic cc_rd_i,
   input  logic dma_i,
   input  logic w1c_i,
   output logic flag_o
);

   logic set_ev;
   logic clr_ev;
   logic flag_q;

   // capture mode picks both the set source and the software clear source
   always_comb begin
      if (capture_mode_i) begin
         set_ev = cap_valid_i;
         clr_ev = cc_rd_i | dma_i | w1c_i;
      end else begin
         set_ev = cmp_match_i;
         clr_ev = ack_i | dma_i | w1c_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_cmp_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture_mode_i && cmp_match_i) |=> flag_o);

   p_cap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_mode_i && cap_valid_i) |=> flag_o);

   p_ack_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_mode_i && flag_o && ack_i && !cc_rd_i && !dma_i && !w1c_i) |=> flag_o);

   p_dma_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_i && !cmp_match_i && !cap_valid_i) |=> !flag_o);

endmodule

// File: rtl/tc_irq_err_flag.sv
module tc_irq_err_flag #(
   parameter int NCH           = 4,
   parameter bit HAS_FAULT_EXT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     mode_i,
   input  logic           fault_i,
   input  logic [NCH-1:0] cap_ovf_i,
   input  logic           qdec_idx_err_i,
   input  logic           ack_i,
   input  logic           w1c_i,
   output logic           flag_o
);
   import tc_irq_pkg::*;

   tc_mode_e mode;
   logic     fault_term;
   logic     ovf_term;
   logic     idx_term;
   logic     set_ev;
   logic     clr_ev;
   logic     flag_q;

   assign mode = tc_mode_e'(mode_i);

   generate
      if (HAS_FAULT_EXT) begin : g_fault
         assign fault_term = fault_i & is_fault_mode(mode);
      end else begin : g_no_fault
         assign fault_term = 1'b0 & fault_i;
      end
   endgenerate

   assign ovf_term = (mode == TM_CAPTURE) & (|cap_ovf_i);
   assign idx_term = (mode == TM_QDEC) & qdec_idx_err_i;
   assign set_ev   = fault_term | ovf_term | idx_term;
   assign clr_ev   = ack_i | w1c_i;

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   generate
      if (HAS_FAULT_EXT) begin : g_fault_chk
         p_fault_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_i && (mode_i inside {3'd1, 3'd2, 3'd3})) |=> flag_o);
      end
   endgenerate

   p_capovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 3'd4) && (cap_ovf_i != '0)) |=> flag_o);

   p_ack_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !fault_i && !qdec_idx_err_i && (cap_ovf_i == '0)) |=> !flag_o);

endmodule

// File: rtl/tc_irq_ovf_flag.sv
module tc_irq_ovf_flag (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_i,
   input  logic       cnt_top_i,
   input  logic       cnt_bottom_i,
   input  logic       ack_i,
   input  logic       w1c_i,
   input  logic       dma_wr_i,
   output logic       flag_o
);
   import tc_irq_pkg::*;

   tc_mode_e mode;
   logic     set_ev;
   logic     clr_ev;
   logic     flag_q;

   assign mode   = tc_mode_e'(mode_i);
   assign set_ev = (mode == TM_PWM_DS) ? cnt_bottom_i : cnt_top_i;
   assign clr_ev = ack_i | w1c_i | dma_wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_bottom_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 3'd3) && cnt_bottom_i) |=> flag_o);

   p_top_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i != 3'd3) && cnt_top_i) |=> flag_o);

   p_dma_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr_i && !cnt_top_i && !cnt_bottom_i) |=> !flag_o);

endmodule

// File: rtl/tc_irq_flags.sv
module tc_irq_flags #(
   parameter int NCH           = 4,
   parameter bit HAS_FAULT_EXT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     mode_i,
   input  logic [NCH-1:0] cmp_match_i,
   input  logic [NCH-1:0] cap_valid_i,
   input  logic [NCH-1:0] cap_ovf_i,
   input  logic           fault_i,
   input  logic           qdec_idx_err_i,
   input  logic           cnt_top_i,
   input  logic           cnt_bottom_i,
   input  logic [NCH-1:0] ack_ch_i,
   input  logic           ack_err_i,
   input  logic           ack_ovf_i,
   input  logic           reg_wr_i,
   input  logic [7:0]     reg_wdata_i,
   input  logic [NCH-1:0] cc_rd_i,
   input  logic [NCH-1:0] dma_cc_i,
   input  logic           dma_cnt_wr_i,
   input  logic [NCH-1:0] en_ch_i,
   input  logic           en_err_i,
   input  logic           en_ovf_i,
   output logic [7:0]     flags_o,
   output logic [NCH-1:0] irq_ch_o,
   output logic           irq_err_o,
   output logic           irq_ovf_o,
   output logic [NCH-1:0] dma_ch_req_o,
   output logic           dma_ovf_req_o
);
   import tc_irq_pkg::*;

   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("tc_irq_flags: NCH must lie in 1..4");
      end
   endgenerate

   logic [FLAG_W-1:0] w1c_vec;
   logic [NCH-1:0]    ch_flag;
   logic              err_flag;
   logic              ovf_flag;
   logic              capture_mode;
   logic [1:0]        unused_rsvd_w1c;

   assign w1c_vec         = reg_wdata_i & {FLAG_W{reg_wr_i}};
   assign unused_rsvd_w1c = w1c_vec[3:2];
   assign capture_mode    = (tc_mode_e'(mode_i) == TM_CAPTURE);

   genvar k;
   generate
      for (k = 0; k < NCH; k++) begin : g_ch
         tc_irq_chan_flag u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .capture_mode_i (capture_mode),
            .cmp_match_i    (cmp_match_i[k]),
            .cap_valid_i    (cap_valid_i[k]),
            .ack_i          (ack_ch_i[k]),
            .cc_rd_i        (cc_rd_i[k]),
            .dma_i          (dma_cc_i[k]),
            .w1c_i          (w1c_vec[CH_BASE+k]),
            .flag_o         (ch_flag[k])
         );
      end
   endgenerate

   tc_irq_err_flag #(
      .NCH           (NCH),
      .HAS_FAULT_EXT (HAS_FAULT_EXT)
   ) u_err (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_i         (mode_i),
      .fault_i        (fault_i),
      .cap_ovf_i      (cap_ovf_i),
      .qdec_idx_err_i (qdec_idx_err_i),
      .ack_i          (ack_err_i),
      .w1c_i          (w1c_vec[ERR_BIT]),
      .flag_o         (err_flag)
   );

   tc_irq_ovf_flag u_ovf (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_i),
      .cnt_top_i    (cnt_top_i),
      .cnt_bottom_i (cnt_bottom_i),
      .ack_i        (ack_ovf_i),
      .w1c_i        (w1c_vec[OVF_BIT]),
      .dma_wr_i     (dma_cnt_wr_i),
      .flag_o       (ovf_flag)
   );

   // flag byte assembly; absent channels and reserved bits read zero
   always_comb begin
      flags_o          = '0;
      flags_o[OVF_BIT] = ovf_flag;
      flags_o[ERR_BIT] = err_flag;
      for (int i = 0; i < NCH; i++) flags_o[CH_BASE+i] = ch_flag[i];
   end

   assign irq_ch_o      = ch_flag & en_ch_i;
   assign irq_err_o     = err_flag & en_err_i;
   assign irq_ovf_o     = ovf_flag & en_ovf_i;
   assign dma_ch_req_o  = ch_flag;
   assign dma_ovf_req_o = ovf_flag;

   p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i[OVF_BIT] && !cnt_top_i && !cnt_bottom_i) |=> !flags_o[OVF_BIT]);

   p_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && !reg_wdata_i[ERR_BIT] && flags_o[ERR_BIT] && !ack_err_i) |=> flags_o[ERR_BIT]);

endmodule

// File: tb/tc_irq_flags_tb_top.sv
module tc_irq_flags_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;

   typedef struct {
      string      tag;
      logic [7:0] flags;
      logic [3:0] en_ch;
      logic       en_err;
      logic       en_ovf;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2:0]     mode_i = 3'd0;
   logic [NCH-1:0] cmp_match_i = '0, cap_valid_i = '0, cap_ovf_i = '0;
   logic           fault_i = 1'b0, qdec_idx_err_i = 1'b0, cnt_top_i = 1'b0, cnt_bottom_i = 1'b0;
   logic [NCH-1:0] ack_ch_i = '0;
   logic           ack_err_i = 1'b0, ack_ovf_i = 1'b0, reg_wr_i = 1'b0;
   logic [7:0]     reg_wdata_i = '0;
   logic [NCH-1:0] cc_rd_i = '0, dma_cc_i = '0;
   logic           dma_cnt_wr_i = 1'b0;
   logic [NCH-1:0] en_ch_i = '1;
   logic           en_err_i = 1'b1, en_ovf_i = 1'b1;
   logic [7:0]     flags_o;
   logic [NCH-1:0] irq_ch_o, dma_ch_req_o;
   logic           irq_err_o, irq_ovf_o, dma_ovf_req_o;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tc_irq_flags #(.NCH(NCH), .HAS_FAULT_EXT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .cmp_match_i(cmp_match_i), .cap_valid_i(cap_valid_i), .cap_ovf_i(cap_ovf_i),
      .fault_i(fault_i), .qdec_idx_err_i(qdec_idx_err_i),
      .cnt_top_i(cnt_top_i), .cnt_bottom_i(cnt_bottom_i),
      .ack_ch_i(ack_ch_i), .ack_err_i(ack_err_i), .ack_ovf_i(ack_ovf_i),
      .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .cc_rd_i(cc_rd_i), .dma_cc_i(dma_cc_i), .dma_cnt_wr_i(dma_cnt_wr_i),
      .en_ch_i(en_ch_i), .en_err_i(en_err_i), .en_ovf_i(en_ovf_i),
      .flags_o(flags_o), .irq_ch_o(irq_ch_o), .irq_err_o(irq_err_o),
      .irq_ovf_o(irq_ovf_o), .dma_ch_req_o(dma_ch_req_o), .dma_ovf_req_o(dma_ovf_req_o)
   );

   // observed bundle: {dma_ch, dma_ovf, irq_ovf, irq_err, irq_ch, flags}
   function automatic logic [18:0] expect_vec(input exp_t e);
      return {e.flags[7:4], e.flags[0], e.flags[0] & e.en_ovf, e.flags[1] & e.en_err,
              e.flags[7:4] & e.en_ch, e.flags};
   endfunction

   task automatic compare(input string tag, input logic [18:0] exp_v);
      logic [18:0] act;
      act = {dma_ch_req_o, dma_ovf_req_o, irq_ovf_o, irq_err_o, irq_ch_o, flags_o};
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic clear_strobes();
      cmp_match_i = '0; cap_valid_i = '0; cap_ovf_i = '0;
      fault_i = 1'b0; qdec_idx_err_i = 1'b0; cnt_top_i = 1'b0; cnt_bottom_i = 1'b0;
      ack_ch_i = '0; ack_err_i = 1'b0; ack_ovf_i = 1'b0;
      reg_wr_i = 1'b0; reg_wdata_i = '0; cc_rd_i = '0; dma_cc_i = '0; dma_cnt_wr_i = 1'b0;
   endtask

   // driver: strobes already set at a falling edge; queue expectation, hold one cycle
   task automatic step(input string tag, input logic [7:0] exp_flags);
      exp_t e;
      e.tag = tag; e.flags = exp_flags;
      e.en_ch = en_ch_i; e.en_err = en_err_i; e.en_ovf = en_ovf_i;
      sb_q.push_back(e);
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic wr(input logic [7:0] d);
      reg_wr_i = 1'b1; reg_wdata_i = d;
   endtask

   // monitor: result due one rising edge after the stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.tag, expect_vec(e));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      r.tag = "R1 in reset"; r.flags = 8'h00; r.en_ch = '1; r.en_err = 1'b1; r.en_ovf = 1'b1;
      compare(r.tag, expect_vec(r));
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset", expect_vec(r));

      mode_i = 3'd0;
      cmp_match_i = 4'b0001;            step("R3 compare sets A", 8'h10);
      cap_valid_i = 4'b0010;            step("R3 cap_valid ignored", 8'h10);
      cc_rd_i = 4'b0001;                step("R4 read no clear", 8'h10);
      ack_ch_i = 4'b0001;               step("R4 ack clears", 8'h00);
      cmp_match_i = 4'b1111; cnt_top_i = 1'b1; step("R3 R9 all set", 8'hF1);
      wr(8'h00);                        step("R6 zero write keeps", 8'hF1);
      wr(8'h0C);                        step("R2 reserved write", 8'hF1);
      wr(8'h30);                        step("R6 w1c B A", 8'hC1);
      dma_cc_i = 4'b1000;               step("R7 dma clears D", 8'h41);
      dma_cnt_wr_i = 1'b1;              step("R10 dma cnt clears ovf", 8'h40);
      en_ch_i = 4'b0000;                step("R12 enable gates irq", 8'h40);
      en_ch_i = 4'b1111; ack_ch_i = 4'b0100; cmp_match_i = 4'b0100;
                                        step("R11 set beats ack", 8'h40);
      ack_ch_i = 4'b0100;               step("R4 ack clears C", 8'h00);
      cnt_bottom_i = 1'b1;              step("R9 bottom ignored normal", 8'h00);
      mode_i = 3'd3; cnt_top_i = 1'b1;  step("R9 top ignored dual", 8'h00);
      cnt_bottom_i = 1'b1;              step("R9 bottom sets dual", 8'h01);
      ack_ovf_i = 1'b1;                 step("R10 ack clears ovf", 8'h00);
      mode_i = 3'd0; fault_i = 1'b1;    step("R8 fault ignored normal", 8'h00);
      mode_i = 3'd2; fault_i = 1'b1;    step("R8 fault sets pwm", 8'h02);
      dma_cnt_wr_i = 1'b1; dma_cc_i = 4'b1111; step("R13 dma keeps err", 8'h02);
      ack_err_i = 1'b1;                 step("R13 ack clears err", 8'h00);
      mode_i = 3'd1; fault_i = 1'b1; ack_err_i = 1'b1; step("R11 fault beats ack", 8'h02);
      en_err_i = 1'b0;                  step("R12 err gated", 8'h02);
      en_err_i = 1'b1; wr(8'h02);       step("R13 w1c clears err", 8'h00);
      mode_i = 3'd4; cap_ovf_i = 4'b0100; step("R8 cap ovf sets", 8'h02);
      wr(8'h02);                        step("R6 w1c err", 8'h00);
      fault_i = 1'b1;                   step("R8 fault ignored capture", 8'h00);
      mode_i = 3'd5; qdec_idx_err_i = 1'b1; step("R8 index err sets", 8'h02);
      mode_i = 3'd4; qdec_idx_err_i = 1'b1; wr(8'h02); step("R8 index ignored capture", 8'h00);
      cmp_match_i = 4'b1111;            step("R5 compare ignored", 8'h00);
      cap_valid_i = 4'b0011;            step("R5 cap_valid sets", 8'h30);
      ack_ch_i = 4'b1111;               step("R5 ack no clear", 8'h30);
      cc_rd_i = 4'b0001;                step("R5 read clears A", 8'h20);
      dma_cc_i = 4'b0010;               step("R7 dma clears B", 8'h00);
      cap_valid_i = 4'b0001; cc_rd_i = 4'b0001; step("R11 valid beats read", 8'h10);
      cnt_top_i = 1'b1;                 step("R9 top in capture", 8'h11);
      en_ovf_i = 1'b0;                  step("R12 ovf gated", 8'h11);
      en_ovf_i = 1'b1; wr(8'hFF);       step("R6 clear all", 8'h00);

      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule